// File: doc/BRIEF.md
# Differential Clock Output Gating Controller

This block fans one reference clock out to a set of differential output pairs (eight by default) and decides, pair by pair, whether each pair toggles, parks at a fixed driven level, or releases its drivers. The block runs on a sampling clock at twice the reference rate. An internal phase generator rebuilds the reference waveform, either at full rate (one toggle per sampling cycle) or at half rate (one toggle every two cycles).

Three kinds of control act on the pairs: a per-pair enable (a strap pin and a register bit, both required), a global stop request, and a global power-down request. One inversion strap flips the sense of the enable pins, the stop pin and the power-down pin together. A register mask chooses which pairs obey the stop request. Two register bits choose, separately for stop and for power-down, whether an affected pair parks driven or goes high-impedance. Every change of a pair's state is delayed until the end of a complete low phase of the reconstructed clock, so that no runt pulse appears. A sticky lock flag records that the lock input has been seen high.

Top module: `dclk_gate_top`

## Requirements
- R1: Half rate is selected when `div_pin_ni` is 0 or `cfg_full_rate_i` (register 0 bit 0, reset default 1) is 0. A running pair then toggles once every two sampling cycles. Otherwise it toggles on every sampling cycle.
- R2: After reset every pair is parked driven (`clk_p_o`=1, `clk_n_o`=0, `drv_en_o`=1) and `lock_o` is 0.
- R3: A pair is enabled only when its enable pin (after strap inversion) is 1 and its `oe_reg_i` bit is 1. A disabled pair takes the power-down choice of `cfg_pd_hiz_i`.
- R4: With `inv_strap_i`=1, the enable pins, the stop pin and the power-down pin are all read with inverted sense. With `inv_strap_i`=0 they are read as they are.
- R5: While stop is active (`stop_pin_ni`=0 with strap 0), each pair whose `stop_mask_i` bit is 1 stops. It parks when `cfg_stop_hiz_i` (register 0 bit 6) is 0 and goes high-impedance when that bit is 1.
- R6: A pair whose `stop_mask_i` bit (register 2, default 0) is 0 keeps running regardless of the stop request.
- R7: A parked pair shows `clk_p_o`=1, `clk_n_o`=0, `drv_en_o`=1. A high-impedance pair shows `drv_en_o`=0 with both data outputs at 0.
- R8: Power-down (`pdn_pin_ni`=0 with strap 0) stops every pair, overriding the enables and the stop mask. The pairs park or go high-impedance according to `cfg_pd_hiz_i` (register 0 bit 7).
- R9: A pair changes state only at the end of a complete low phase of the reconstructed clock. Every high or low run on a driven output therefore lasts at least one half period.
- R10: `lock_o` rises after `lock_i` is sampled high and stays high after `lock_i` falls. It clears only on reset or while power-down is active.
- R11: A running pair drives `drv_en_o`=1, with `clk_n_o` always the complement of `clk_p_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock, twice the reference rate |
| rst_ni | input | 1 | Synchronous reset, active low |
| div_pin_ni | input | 1 | Half-rate select pin, active low |
| oe_pin_i | input | NUM_OUT | Per-pair enable pins, active high when strap is 0 |
| stop_pin_ni | input | 1 | Stop request pin, active low when strap is 0 |
| pdn_pin_ni | input | 1 | Power-down pin, active low when strap is 0 |
| inv_strap_i | input | 1 | Inverts the enable, stop and power-down pins |
| cfg_full_rate_i | input | 1 | Register 0 bit 0: 1 full rate, 0 half rate |
| cfg_stop_hiz_i | input | 1 | Register 0 bit 6: stopped pairs 0 park, 1 high-impedance |
| cfg_pd_hiz_i | input | 1 | Register 0 bit 7: powered-down or disabled pairs 0 park, 1 high-impedance |
| oe_reg_i | input | NUM_OUT | Register 1: per-pair enable bits |
| stop_mask_i | input | NUM_OUT | Register 2: 1 lets the stop request stop that pair |
| lock_i | input | 1 | Lock indication, synchronous to clk_i |
| clk_p_o | output | NUM_OUT | True output of each pair |
| clk_n_o | output | NUM_OUT | Complement output of each pair |
| drv_en_o | output | NUM_OUT | Driver enable of each pair (0 = high-impedance) |
| lock_o | output | 1 | Sticky lock flag |

## Verification
The assertions assume the following about the inputs. `lock_i`, the register inputs and `div_pin_ni` are synchronous to `clk_i`. Only the stop and power-down pins arrive asynchronously, and those pass through a two-stage synchronizer. The bench changes every input at the falling edge of `clk_i`. It lets each setting settle well past the synchronizer delay plus one half-rate period before it judges steady-state behaviour. It starts the settings at shifting clock phases, so that state changes land in both high and low phases. A run-length monitor checks R9 on every driven output. The monitor is muted for a few cycles after a rate change, because the half-period itself changes then.

// File: rtl/dclk_pkg.sv
// Shared definitions for the differential clock gating controller.
// Assumes: nothing beyond IEEE 1800-2017.
package dclk_pkg;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        LANE_PARK = 2'd0,
        LANE_RUN  = 2'd1,
        LANE_HIZ  = 2'd2
    } lane_mode_e;
endpackage

// File: rtl/dclk_phase.sv
// Rebuilds the reference clock waveform at full or divided rate and flags the
// cycle that ends a low phase (the only point where lanes may change state).
// Assumes: div_i is synchronous to clk_i; DIV_RATIO >= 2.
module dclk_phase #(
    parameter int DIV_RATIO = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic div_i,
    output logic ph_o,
    output logic bound_o
);
    localparam int CNT_W = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_RATIO - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             ph_q;
    logic             tog;

    // decide whether the waveform toggles at the next edge
    always_comb tog = !div_i || (cnt_q == CNT_LAST);

    // count sampling cycles within one half period and toggle the phase
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            ph_q  <= 1'b0;
        end else begin
            cnt_q <= (div_i && !tog) ? cnt_q + 1'b1 : '0;
            if (tog) ph_q <= !ph_q;
        end
    end

    assign ph_o    = ph_q;
    assign bound_o = !ph_q && tog;

    AST_DIV_NO_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && div_i && $past(div_i) && !$stable(ph_q)) |=> $stable(ph_q)); // R1
endmodule

// File: rtl/dclk_sync.sv
// Multi-bit level synchronizer with a reset value of all zeros (inactive).
// Assumes: each bit is an independent level; STAGES >= 2.
module dclk_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // capture the asynchronous levels
            always_ff @(posedge clk_i) begin
                if (!rst_ni) stg_q[s] <= '0;
                else         stg_q[s] <= d_i;
            end
        end else begin : g_next
            // shift through the remaining stages
            always_ff @(posedge clk_i) begin
                if (!rst_ni) stg_q[s] <= '0;
                else         stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dclk_lane.sv
// One output pair: chooses run, park or high-impedance from the synchronized
// requests and commits the choice only at the end of a low phase.
// Assumes: pd_i and stop_i already synchronized; bound_i from dclk_phase.
module dclk_lane
    import dclk_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ph_i,
    input  logic bound_i,
    input  logic pd_i,
    input  logic stop_i,
    input  logic en_i,
    input  logic mask_i,
    input  logic stop_hiz_i,
    input  logic pd_hiz_i,
    output logic p_o,
    output logic n_o,
    output logic oe_o
);
    lane_mode_e mode_q, mode_nxt;

    // priority: power-down, then disable, then masked stop, else run
    always_comb begin
        if (pd_i || !en_i)          mode_nxt = pd_hiz_i ? LANE_HIZ : LANE_PARK;
        else if (stop_i && mask_i)  mode_nxt = stop_hiz_i ? LANE_HIZ : LANE_PARK;
        else                        mode_nxt = LANE_RUN;
    end

    // commit the mode only at the end of a full low phase
    always_ff @(posedge clk_i) begin
        if (!rst_ni)      mode_q <= LANE_PARK;
        else if (bound_i) mode_q <= mode_nxt;
    end

    // drive the pair from the committed mode
    always_comb begin
        unique case (mode_q)
            LANE_RUN: begin p_o = ph_i; n_o = !ph_i; oe_o = 1'b1; end
            LANE_HIZ: begin p_o = 1'b0; n_o = 1'b0;  oe_o = 1'b0; end
            default:  begin p_o = 1'b1; n_o = 1'b0;  oe_o = 1'b1; end
        endcase
    end

    AST_CHANGE_AFTER_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && mode_q != $past(mode_q)) |-> !$past(ph_i)); // R9
    AST_PD_OVERRIDES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(pd_i) && $past(bound_i)) |-> mode_q != LANE_RUN); // R8
    AST_UNMASKED_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(!pd_i && en_i && !mask_i && bound_i)) |-> mode_q == LANE_RUN); // R6
endmodule

// File: rtl/dclk_gate_top.sv
// Top of the differential clock gating controller: applies strap inversion,
// synchronizes stop and power-down, generates the waveform, drives all lanes
// and keeps the sticky lock flag.
// Assumes: clk_i runs at twice the reference rate; register inputs, lock_i and
// div_pin_ni are synchronous to clk_i.
module dclk_gate_top
    import dclk_pkg::*;
#(
    parameter int NUM_OUT   = 8,
    parameter int DIV_RATIO = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               div_pin_ni,
    input  logic [NUM_OUT-1:0] oe_pin_i,
    input  logic               stop_pin_ni,
    input  logic               pdn_pin_ni,
    input  logic               inv_strap_i,
    input  logic               cfg_full_rate_i,
    input  logic               cfg_stop_hiz_i,
    input  logic               cfg_pd_hiz_i,
    input  logic [NUM_OUT-1:0] oe_reg_i,
    input  logic [NUM_OUT-1:0] stop_mask_i,
    input  logic               lock_i,
    output logic [NUM_OUT-1:0] clk_p_o,
    output logic [NUM_OUT-1:0] clk_n_o,
    output logic [NUM_OUT-1:0] drv_en_o,
    output logic               lock_o
);
    logic [1:0]         req_raw, req_s;
    logic               stop_s, pd_s;
    logic [NUM_OUT-1:0] en_ok;
    logic               div, ph, bound;
    logic               lock_q;

    // active-high requests after strap inversion: bit0 stop, bit1 power-down
    always_comb begin
        req_raw[0] = !(stop_pin_ni ^ inv_strap_i);
        req_raw[1] = !(pdn_pin_ni ^ inv_strap_i);
    end

    dclk_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (req_raw),
        .q_o    (req_s)
    );
    assign stop_s = req_s[0];
    assign pd_s   = req_s[1];

    // per-lane enable needs both the pin (after inversion) and the register
    always_comb en_ok = (oe_pin_i ^ {NUM_OUT{inv_strap_i}}) & oe_reg_i;

    // half rate when either the pin or the register asks for it
    always_comb div = !div_pin_ni || !cfg_full_rate_i;

    dclk_phase #(.DIV_RATIO(DIV_RATIO)) u_phase (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .div_i   (div),
        .ph_o    (ph),
        .bound_o (bound)
    );

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
        dclk_lane u_lane (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .ph_i       (ph),
            .bound_i    (bound),
            .pd_i       (pd_s),
            .stop_i     (stop_s),
            .en_i       (en_ok[i]),
            .mask_i     (stop_mask_i[i]),
            .stop_hiz_i (cfg_stop_hiz_i),
            .pd_hiz_i   (cfg_pd_hiz_i),
            .p_o        (clk_p_o[i]),
            .n_o        (clk_n_o[i]),
            .oe_o       (drv_en_o[i])
        );
    end

    // sticky lock flag, cleared by reset or power-down
    always_ff @(posedge clk_i) begin
        if (!rst_ni || pd_s) lock_q <= 1'b0;
        else                 lock_q <= lock_q || lock_i;
    end
    assign lock_o = lock_q;

    AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lock_q && !pd_s) |=> lock_q); // R10
    AST_LOCK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pd_s |=> !lock_q); // R10
endmodule

// File: tb/sim_dclk_gate_top.sv
module sim_dclk_gate_top;
    localparam int CLK_PERIOD = 10;
    localparam int NO = 8;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          div_n = 1'b1, stop_n = 1'b1, pdn_n = 1'b1, inv = 1'b0;
    logic          full_rate = 1'b1, stop_hiz = 1'b0, pd_hiz = 1'b0, lock_in = 1'b0;
    logic [NO-1:0] oe_pin = '1, oe_reg = '1, mask = '0;
    logic [NO-1:0] p, n, en;
    logic          lock_out;
    int            checks = 0, errors = 0;

    dclk_gate_top #(.NUM_OUT(NO)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .div_pin_ni(div_n), .oe_pin_i(oe_pin),
        .stop_pin_ni(stop_n), .pdn_pin_ni(pdn_n), .inv_strap_i(inv),
        .cfg_full_rate_i(full_rate), .cfg_stop_hiz_i(stop_hiz), .cfg_pd_hiz_i(pd_hiz),
        .oe_reg_i(oe_reg), .stop_mask_i(mask), .lock_i(lock_in),
        .clk_p_o(p), .clk_n_o(n), .drv_en_o(en), .lock_o(lock_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R9 run-length monitor on driven outputs
    int   run_len [NO];
    logic prev_p  [NO];
    int   quiet = 6;
    logic prev_div = 1'b0;
    always @(negedge clk) begin
        logic div_now;
        div_now = !div_n || !full_rate;
        if (div_now != prev_div || !rst_n) quiet = 6;
        else if (quiet > 0) quiet--;
        prev_div = div_now;
        for (int i = 0; i < NO; i++) begin
            if (!rst_n || !en[i]) run_len[i] = 0;
            else if (run_len[i] == 0) begin prev_p[i] = p[i]; run_len[i] = 1; end
            else if (p[i] == prev_p[i]) run_len[i]++;
            else begin
                if (quiet == 0) check(run_len[i] >= (div_now ? 2 : 1), "R9 runt", run_len[i], div_now ? 2 : 1);
                prev_p[i] = p[i];
                run_len[i] = 1;
            end
        end
    end

    // expected state per lane: 0 park, 1 run, 2 hiz; also names the requirement
    function automatic int exp_mode(input int i, output string req);
        bit pd_a, st_a, en_a;
        pd_a = !(pdn_n ^ inv);
        st_a = !(stop_n ^ inv);
        en_a = (oe_pin[i] ^ inv) && oe_reg[i];
        if (pd_a)                 begin req = "R8 R7"; return pd_hiz ? 2 : 0; end
        if (!en_a)                begin req = "R3 R7"; return pd_hiz ? 2 : 0; end
        if (st_a && mask[i])      begin req = "R5 R7"; return stop_hiz ? 2 : 0; end
        if (st_a)                 req = "R6 R11";
        else                      req = "R1 R11";
        return 1;
    endfunction

    task automatic observe();
        logic [NO-1:0] sp [8], sn [8], se [8];
        bit dv;
        dv = !div_n || !full_rate;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            sp[k] = p; sn[k] = n; se[k] = en;
        end
        for (int i = 0; i < NO; i++) begin
            string req;
            int m, tg, act;
            bit ok;
            m = exp_mode(i, req);
            if (inv) req = {req, " R4"};
            if (m == 1) begin
                ok = 1; tg = 0;
                for (int k = 0; k < 8; k++) begin
                    if (!se[k][i] || sn[k][i] == sp[k][i]) ok = 0;
                    if (k > 0 && sp[k][i] != sp[k-1][i]) tg++;
                end
                if (dv) ok = ok && (tg == 3 || tg == 4);
                else    ok = ok && (tg == 7);
                check(ok, req, tg, dv ? 4 : 7);
            end else begin
                int exp_v;
                exp_v = (m == 0) ? 6 : 0;
                act = exp_v;
                for (int k = 0; k < 8; k++) begin
                    int v;
                    v = {se[k][i], sp[k][i], sn[k][i]};
                    if (v != exp_v) act = v;
                end
                check(act == exp_v, req, act, exp_v);
            end
        end
    endtask

    bit done = 0;
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R2 reset state sampled right after release
        for (int i = 0; i < NO; i++)
            check({en[i], p[i], n[i]} == 3'b110, "R2", {en[i], p[i], n[i]}, 6);
        check(lock_out == 1'b0, "R2 lock", lock_out, 0);

        // sweep strap, power-down, stop, park/hiz choices and rate
        for (int sc = 0; sc < 64; sc++) begin
            @(negedge clk);
            inv      = sc[0];
            pdn_n    = sc[1] ^ inv ^ 1'b1;   // sc[1]=1 -> power-down active
            stop_n   = sc[2] ^ inv ^ 1'b1;   // sc[2]=1 -> stop active
            stop_hiz = sc[3];
            pd_hiz   = sc[4];
            if (sc[5]) begin div_n = sc[0]; full_rate = !sc[0]; end
            else       begin div_n = 1'b1;  full_rate = 1'b1;   end
            oe_pin   = 8'hB7 ^ {NO{inv}};
            oe_reg   = 8'hEE;
            mask     = 8'h5A;
            repeat (16 + (sc % 3)) @(negedge clk);
            observe();
        end

        // R10 sticky lock
        @(negedge clk);
        inv = 1'b0; pdn_n = 1'b1; stop_n = 1'b1; lock_in = 1'b0;
        repeat (5) @(negedge clk);
        check(lock_out == 1'b0, "R10 before lock", lock_out, 0);
        lock_in = 1'b1;
        @(negedge clk);
        lock_in = 1'b0;
        @(negedge clk);
        check(lock_out == 1'b1, "R10 set", lock_out, 1);
        repeat (10) @(negedge clk);
        check(lock_out == 1'b1, "R10 held", lock_out, 1);
        pdn_n = 1'b0;
        repeat (5) @(negedge clk);
        check(lock_out == 1'b0, "R10 cleared by power-down", lock_out, 0);
        pdn_n = 1'b1;
        repeat (5) @(negedge clk);
        check(lock_out == 1'b0, "R10 stays clear", lock_out, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule